// File: doc/BRIEF.md
# SDRAM Row Command Broadcaster

This block sends one SDRAM initialisation command to every populated physical bank behind two module sockets. A command code, an 8-bit population value and a CAS-latency select are presented with a start pulse. The block writes the command code into the upper field of an 8-bit control register. It then visits socket 0 and socket 1 in turn. For each populated side it issues one read access over a request/acknowledge handshake.

Each socket's 4-bit code decodes to a module size and a second-side offset. The sockets are packed in memory one after the other. The target address is the socket's running start address, plus the second-side offset for the second bank, plus a command offset. The command offset is nonzero only for the mode-register command, and there it depends on the socket and on the CAS latency. Empty sockets and single-sided modules are skipped. The normal-operation command touches only the control register. A code that must never be programmed is treated as an empty socket and raises a sticky error flag.

Top module: `sdram_cmd_bcast`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `req_o` and `err_o` are low, and `ctrl_o` equals the parameter CTRL_INIT (default 8'h0B).
- R2: A start is taken only while the block is idle, meaning `busy_o` and `done_o` are both low. In the cycle after it is taken, `ctrl_o[7:5]` holds `cmd_i`. `ctrl_o[4:0]` never changes. A start while busy has no effect on `ctrl_o` or on the accesses. Command codes: 0 normal operation, 1 no-operation, 2 precharge-all, 3 mode-register-set, 4 refresh. Codes 5 to 7 behave like 1.
- R3: Socket s uses bits [4s+3:4s] of `rowpop_i`. Codes 0..F give sizes in MB of 0,8,0,16,16,24,32,32,48,64,64,96,128,128,192,256. The same codes give second-side offsets in MB of 0,0,0,8,0,16,16,0,32,32,0,64,64,0,128,128.
- R4: Socket 0 starts at address 0. Socket 1 starts at the size of socket 0 multiplied by 2^20. Accesses come in this order: socket 0 first side, socket 0 second side, socket 1 first side, socket 1 second side.
- R5: A socket with a nonzero size gets one access at start plus command offset. When its second-side offset is also nonzero, it gets a second access at start plus second-side offset times 2^20 plus command offset.
- R6: For mode-register-set, the command offset is 0x1D0 for socket 0 with `cl3_i`=1, 0x650 for socket 1 with `cl3_i`=1, 0x150 for socket 0 with `cl3_i`=0, and 0x1A0 for socket 1 with `cl3_i`=0. For every other command it is 0.
- R7: The normal-operation command issues no access. `done_o` pulses in the cycle after the start.
- R8: Code 2 counts as an empty socket. Any taken start whose population value holds code 2 in either socket sets `err_o`, which stays high until reset.
- R9: `req_o` stays high with a stable `addr_o` until `ack_i` is sampled high. The next access begins only after that.
- R10: `done_o` is a one-cycle pulse after the last access is acknowledged, or after the scan when no access is needed. `busy_o` and `req_o` are low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| cmd_i | input | 3 | SDRAM command code |
| rowpop_i | input | 8 | Two 4-bit socket population codes |
| cl3_i | input | 1 | 1 selects CAS latency 3, 0 selects CAS latency 2 |
| req_o | output | 1 | Access request |
| addr_o | output | 32 | Access address |
| ack_i | input | 1 | Access acknowledge |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ctrl_o | output | 8 | Control register, command in bits 7:5 |
| err_o | output | 1 | Sticky illegal-code flag |

## Verification
The vector table covers a range of population patterns:
- A lone single-sided socket 0, which checks the base case.
- Two dual-sided sockets, which separate the second-side offset from socket 1's start address.
- An empty socket 0, which shows that socket 1 then starts at 0.
- Both sockets fully populated at the largest codes, which checks address accumulation up to 384 MB.

Mode-register-set runs with both CAS-latency settings and with each socket populated. This tells each of the four offsets apart from the plain zero offset, and the mode offsets from the row addresses. Normal operation and an all-empty refresh tell "no access, done at once" apart from a scan of empty sockets. The directed tests check the following:
- The illegal code in socket 0 is skipped and the error flag is raised.
- Reset clears the error flag.
- A start issued during a stalled request leaves the control register and the access list unchanged.

// File: rtl/sdram_bcast_pkg.sv
package sdram_bcast_pkg;

  localparam int NUM_SOCK   = 2;
  localparam int CODE_W     = 4;
  localparam int SIDES      = 2;
  localparam int NUM_SLOT   = NUM_SOCK * SIDES;
  localparam int SLOT_W     = $clog2(NUM_SLOT);
  localparam int MB_W       = 10;
  localparam int MB_SHIFT   = 20;
  localparam int CMD_W      = 3;
  localparam int OFS_W      = 13;
  localparam int POP_W      = NUM_SOCK * CODE_W;

  localparam logic [CMD_W-1:0]  CMD_NORMAL   = 3'd0;
  localparam logic [CMD_W-1:0]  CMD_MODESET  = 3'd3;
  localparam logic [CODE_W-1:0] CODE_ILLEGAL = 4'h2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_REQ  = 2'd2,
    ST_DONE = 2'd3
  } walk_state_e;

  function automatic logic [MB_W-1:0] code_size_mb(input logic [CODE_W-1:0] code);
    logic [MB_W-1:0] r;
    case (code)
      4'h1:          r = 10'd8;
      4'h3, 4'h4:    r = 10'd16;
      4'h5:          r = 10'd24;
      4'h6, 4'h7:    r = 10'd32;
      4'h8:          r = 10'd48;
      4'h9, 4'hA:    r = 10'd64;
      4'hB:          r = 10'd96;
      4'hC, 4'hD:    r = 10'd128;
      4'hE:          r = 10'd192;
      4'hF:          r = 10'd256;
      default:       r = 10'd0;
    endcase
    return r;
  endfunction

  function automatic logic [MB_W-1:0] code_side_mb(input logic [CODE_W-1:0] code);
    logic [MB_W-1:0] r;
    case (code)
      4'h3:          r = 10'd8;
      4'h5, 4'h6:    r = 10'd16;
      4'h8, 4'h9:    r = 10'd32;
      4'hB, 4'hC:    r = 10'd64;
      4'hE, 4'hF:    r = 10'd128;
      default:       r = 10'd0;
    endcase
    return r;
  endfunction

  function automatic logic [OFS_W-1:0] modeset_offset(input int sock, input logic cl3);
    logic [OFS_W-1:0] r;
    r = '0;
    if (sock == 0) r = cl3 ? 13'h1D0 : 13'h150;
    if (sock == 1) r = cl3 ? 13'h650 : 13'h1A0;
    return r;
  endfunction

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sdram_sock_decode.sv
module sdram_sock_decode
  import sdram_bcast_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [MB_W-1:0]   size_mb_o,
  output logic [MB_W-1:0]   side_mb_o,
  output logic              illegal_o
);
  always_comb begin
    illegal_o = (code_i == CODE_ILLEGAL);
    size_mb_o = code_size_mb(code_i);
    side_mb_o = code_side_mb(code_i);
  end
endmodule

// File: rtl/sdram_slot_map.sv
module sdram_slot_map
  import sdram_bcast_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [POP_W-1:0]  rowpop_i,
  input  logic              modeset_i,
  input  logic              cl3_i,
  output logic [NUM_SLOT-1:0] slot_vld_o,
  output logic [ADDR_W-1:0] slot_addr_o [NUM_SLOT]
);
  logic [MB_W-1:0] sock_start [NUM_SOCK+1];
  logic [MB_W-1:0] sock_size  [NUM_SOCK];
  logic [MB_W-1:0] sock_side  [NUM_SOCK];
  logic            sock_bad   [NUM_SOCK];

  assign sock_start[0] = '0;

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    logic [OFS_W-1:0] cmd_ofs;
    logic [MB_W-1:0]  side_start;

    sdram_sock_decode u_dec (
      .code_i    (rowpop_i[s*CODE_W +: CODE_W]),
      .size_mb_o (sock_size[s]),
      .side_mb_o (sock_side[s]),
      .illegal_o (sock_bad[s])
    );

    assign sock_start[s+1] = sock_start[s] + sock_size[s];
    assign side_start      = sock_start[s] + sock_side[s];
    assign cmd_ofs         = modeset_i ? modeset_offset(s, cl3_i) : '0;

    assign slot_vld_o[s*SIDES]     = (sock_size[s] != '0);
    assign slot_vld_o[s*SIDES + 1] = (sock_side[s] != '0) && (sock_size[s] != '0);

    assign slot_addr_o[s*SIDES] =
      (ADDR_W'(sock_start[s]) << MB_SHIFT) + ADDR_W'(cmd_ofs);
    assign slot_addr_o[s*SIDES + 1] =
      (ADDR_W'(side_start) << MB_SHIFT) + ADDR_W'(cmd_ofs);
  end
endmodule

// File: rtl/sdram_cmd_bcast.sv
module sdram_cmd_bcast
  import sdram_bcast_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [7:0]  CTRL_INIT = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [POP_W-1:0]  rowpop_i,
  input  logic              cl3_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        ctrl_o,
  output logic              err_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOT - 1);

  logic rst_sync_n;

  sdram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  walk_state_e       state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [POP_W-1:0]  pop_q;
  logic              mode_q, cl3_q;
  logic [7:0]        ctrl_q, ctrl_d;
  logic              err_q, err_d;
  logic              load_en, addr_en, slot_en;
  logic              in_bad;

  logic [NUM_SLOT-1:0] slot_vld;
  logic [ADDR_W-1:0]   slot_addr [NUM_SLOT];

  sdram_slot_map #(.ADDR_W(ADDR_W)) u_map (
    .rowpop_i    (pop_q),
    .modeset_i   (mode_q),
    .cl3_i       (cl3_q),
    .slot_vld_o  (slot_vld),
    .slot_addr_o (slot_addr)
  );

  always_comb begin
    in_bad = 1'b0;
    for (int s = 0; s < NUM_SOCK; s++) begin
      if (rowpop_i[s*CODE_W +: CODE_W] == CODE_ILLEGAL) in_bad = 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    addr_d  = addr_q;
    ctrl_d  = ctrl_q;
    err_d   = err_q;
    load_en = 1'b0;
    addr_en = 1'b0;
    slot_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_en = 1'b1;
          slot_en = 1'b1;
          slot_d  = '0;
          ctrl_d  = {cmd_i, ctrl_q[4:0]};
          err_d   = err_q | in_bad;
          state_d = (cmd_i == CMD_NORMAL) ? ST_DONE : ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (slot_vld[slot_q]) begin
          addr_en = 1'b1;
          addr_d  = slot_addr[slot_q];
          state_d = ST_REQ;
        end else if (slot_q == LAST_SLOT) begin
          state_d = ST_DONE;
        end else begin
          slot_en = 1'b1;
          slot_d  = slot_q + 1'b1;
        end
      end
      ST_REQ: begin
        if (ack_i) begin
          if (slot_q == LAST_SLOT) begin
            state_d = ST_DONE;
          end else begin
            slot_en = 1'b1;
            slot_d  = slot_q + 1'b1;
            state_d = ST_SCAN;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= CTRL_INIT;
      pop_q  <= '0;
      mode_q <= 1'b0;
      cl3_q  <= 1'b0;
    end else if (load_en) begin
      ctrl_q <= ctrl_d;
      pop_q  <= rowpop_i;
      mode_q <= (cmd_i == CMD_MODESET);
      cl3_q  <= cl3_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  slot_q <= '0;
    else if (slot_en) slot_q <= slot_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign req_o  = (state_q == ST_REQ);
  assign addr_o = addr_q;
  assign busy_o = (state_q == ST_SCAN) || (state_q == ST_REQ);
  assign done_o = (state_q == ST_DONE);
  assign ctrl_o = ctrl_q;
  assign err_o  = err_q;
endmodule

// File: rtl/sdram_cmd_bcast_chk.sv
module sdram_cmd_bcast_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [2:0]        cmd_i,
  input logic              ack_i,
  input logic              req_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [7:0]        ctrl_o,
  input logic              err_o
);
  logic idle_w;
  assign idle_w = !busy_o && !done_o;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o)));

  assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> busy_o);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!req_o && !busy_o));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_ctrl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ctrl_o[4:0]));

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle_w) |=> (ctrl_o[7:5] == $past(cmd_i)));

  assert_normal_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle_w && cmd_i == 3'd0) |=> (done_o && !req_o));
endmodule

bind sdram_cmd_bcast sdram_cmd_bcast_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .cmd_i   (cmd_i),
  .ack_i   (ack_i),
  .req_o   (req_o),
  .addr_o  (addr_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ctrl_o  (ctrl_o),
  .err_o   (err_o)
);

// File: tb/tb_sdram_cmd_bcast.sv
module tb_sdram_cmd_bcast;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  localparam int VW   = 16 + 4*32;

  // fields: cmd[3] rowpop[8] cl3[1] count[3] err[1] addr0..addr3
  localparam logic [VW-1:0] VECS [NVEC] = '{
    {3'd1, 8'h07, 1'b0, 3'd1, 1'b0, 32'h0000_0000, 32'h0, 32'h0, 32'h0},
    {3'd2, 8'h3C, 1'b0, 3'd4, 1'b0, 32'h0000_0000, 32'h0400_0000, 32'h0800_0000, 32'h0880_0000},
    {3'd3, 8'h95, 1'b1, 3'd4, 1'b0, 32'h0000_01D0, 32'h0100_01D0, 32'h0180_0650, 32'h0380_0650},
    {3'd3, 8'hF0, 1'b0, 3'd2, 1'b0, 32'h0000_01A0, 32'h0800_01A0, 32'h0, 32'h0},
    {3'd4, 8'h00, 1'b0, 3'd0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0},
    {3'd0, 8'hFF, 1'b1, 3'd0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0},
    {3'd3, 8'h0E, 1'b0, 3'd2, 1'b0, 32'h0000_0150, 32'h0800_0150, 32'h0, 32'h0},
    {3'd4, 8'hEF, 1'b1, 3'd4, 1'b0, 32'h0000_0000, 32'h0800_0000, 32'h1000_0000, 32'h1800_0000},
    {3'd3, 8'h42, 1'b1, 3'd1, 1'b1, 32'h0000_0650, 32'h0, 32'h0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, cl3_i, ack_i;
  logic [2:0]  cmd_i;
  logic [7:0]  rowpop_i;
  logic        req_o, busy_o, done_o, err_o;
  logic [31:0] addr_o;
  logic [7:0]  ctrl_o;

  int errors = 0;
  int checks = 0;
  int got_n, got_cyc;
  logic [31:0] got_addr [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_bcast dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .rowpop_i(rowpop_i), .cl3_i(cl3_i), .req_o(req_o), .addr_o(addr_o),
    .ack_i(ack_i), .busy_o(busy_o), .done_o(done_o), .ctrl_o(ctrl_o),
    .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_i = 1'b0; ack_i = 1'b0;
    cmd_i = '0; rowpop_i = '0; cl3_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // pulse start, then serve requests until done; records accesses
  task automatic run_walk(input logic [2:0] c, input logic [7:0] rp, input logic cl);
    got_n = 0; got_cyc = 0;
    @(negedge clk);
    cmd_i = c; rowpop_i = rp; cl3_i = cl; start_i = 1'b1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      ack_i = 1'b0;
      got_cyc++;
      if (k == 0) check("R2 ctrl load", {24'h0, ctrl_o}, {24'h0, c, 5'h0B});
      if (done_o) break;
      if (req_o) begin
        if (got_n < 8) got_addr[got_n] = addr_o;
        got_n++;
        ack_i = 1'b1;
      end
    end
    check("R10 done seen", {31'h0, done_o}, 32'h1);
    @(negedge clk);
    check("R10 done one cycle", {31'h0, done_o}, 32'h0);
    check("R10 idle after done", {31'h0, busy_o}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 busy", {31'h0, busy_o}, 32'h0);
    check("R1 done", {31'h0, done_o}, 32'h0);
    check("R1 req", {31'h0, req_o}, 32'h0);
    check("R1 err", {31'h0, err_o}, 32'h0);
    check("R1 ctrl", {24'h0, ctrl_o}, 32'h0000_000B);

    // vector table: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      logic [VW-1:0] e;
      int n;
      e = VECS[v];
      n = int'(e[VW-13 -: 3]);
      run_walk(e[VW-1 -: 3], e[VW-4 -: 8], e[VW-12]);
      check("R4 R5 access count", got_n, n);
      for (int a = 0; a < n && a < got_n; a++)
        check("R3 R4 R5 R6 address", got_addr[a], e[127 - 32*a -: 32]);
      if (e[VW-1 -: 3] == 3'd0)
        check("R7 done next cycle", got_cyc, 1);
      check("R8 err flag", {31'h0, err_o}, {31'h0, e[VW-16]});
    end

    // R8 sticky, then cleared by reset (R1)
    run_walk(3'd1, 8'h07, 1'b0);
    check("R8 err stays", {31'h0, err_o}, 32'h1);
    do_reset();
    check("R1 err cleared", {31'h0, err_o}, 32'h0);

    // R2 and R9: start while a request is stalled
    @(negedge clk);
    cmd_i = 3'd2; rowpop_i = 8'h07; cl3_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 20 && !req_o; k++) @(negedge clk);
    check("R9 req raised", {31'h0, req_o}, 32'h1);
    cmd_i = 3'd1; rowpop_i = 8'hFF; start_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 req held", {31'h0, req_o}, 32'h1);
      check("R9 addr held", addr_o, 32'h0);
    end
    start_i = 1'b0;
    check("R2 ctrl ignores busy start", {24'h0, ctrl_o}, {24'h0, 3'd2, 5'h0B});
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    got_n = 0;
    for (int k = 0; k < 10; k++) begin
      if (req_o) got_n++;
      @(negedge clk);
    end
    check("R2 no extra access", got_n, 0);
    check("R2 idle", {31'h0, busy_o}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule